// File: doc/BRIEF.md
# No-Signal Vertical Free-Run Generator

This block keeps an LCD panel's vertical drive alive when the incoming video loses vertical sync. It counts horizontal line strobes since the last vertical sync. If too many lines pass without a sync, it raises a no-signal flag. From then on it generates the panel's vertical start pulse from its own line count, so frames keep coming at a fixed period.

The frame inversion signal and its complement keep toggling in both states, so the panel stays AC driven. The toggle happens either once per line or once per frame. The timeout and the free-run period both depend on the video standard, and each free-run period is shorter than the matching timeout.

When sync is present, every vertical sync produces one vertical start pulse. The first sync after a loss clears the flag and restarts the counting at once.

Top module: `nosig_vgen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `vst` is 0, `no_sig` is 0, `frp` is 0 and `xfrp` is 1.
- R2: `mode_sel[1]`=1 selects VGA and ignores `mode_sel[0]`. With `mode_sel[1]`=0, `mode_sel[0]`=1 selects NTSC and 0 selects PAL. The loss timeouts are 291 lines for NTSC, 339 for PAL and 873 for VGA.
- R3: `no_sig` goes high in the cycle after the line strobe that is the (timeout+1)-th strobe counted since the last vertical sync or reset. It stays low through the first timeout strobes.
- R4: While `no_sig` is high, `vst` pulses for one cycle every P line strobes, counted from the strobe that declared the loss. P is 269 for NTSC, 321 for PAL and 526 for VGA.
- R5: A `vsync_in` pulse makes `vst` high for exactly the following cycle. In that same following cycle `no_sig` is low, and both line counts restart from zero.
- R6: While `no_sig` is low, `vst` is high only in cycles that follow a `vsync_in` pulse.
- R7: With `inv_line`=0, `frp` toggles in exactly the cycles in which `vst` rises, whether the pulse came from sync or from free-run.
- R8: With `inv_line`=1, `frp` toggles in the cycle after every line strobe, in both the signal and the no-signal states.
- R9: `xfrp` is the complement of `frp` in every cycle.
- R10: A line strobe that arrives in the same cycle as `vsync_in` does not count toward the loss timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low clear |
| line_stb | input | 1 | One-cycle strobe per horizontal line |
| vsync_in | input | 1 | One-cycle vertical sync pulse, polarity already corrected |
| mode_sel | input | 2 | Standard select: bit 1 VGA/TV, bit 0 NTSC/PAL |
| inv_line | input | 1 | 1: invert every line, 0: invert every frame |
| vst | output | 1 | Vertical start pulse |
| frp | output | 1 | Frame/line inversion signal |
| xfrp | output | 1 | Complement of `frp` |
| no_sig | output | 1 | No-signal status flag |

## Verification
The assertions assume that `vsync_in` and `line_stb` are single-cycle pulses. They also assume that two `vsync_in` pulses never fall in adjacent cycles. They treat `mode_sel` as a setting that changes only together with a sync restart.

The stimulus keeps to these assumptions. It spaces line strobes four cycles apart, issues every sync as an isolated one-cycle pulse, and changes the mode only right before a sync. A behavioural model then follows every cycle across all three standards, both inversion selects, repeated loss and recovery, and a sync that lands on a line strobe.

// File: rtl/nosig_vgen_pkg.sv
package nosig_vgen_pkg;

    typedef enum logic [1:0] {
        VM_NTSC = 2'd0,
        VM_PAL  = 2'd1,
        VM_VGA  = 2'd2
    } vmode_e;

    function automatic vmode_e decode_mode(input logic [1:0] sel);
        if (sel[1])
            return VM_VGA;
        else if (sel[0])
            return VM_NTSC;
        else
            return VM_PAL;
    endfunction

endpackage

// File: rtl/nosig_mode_limits.sv
module nosig_mode_limits
    import nosig_vgen_pkg::*;
#(
    parameter int CW       = 11,
    parameter int TMO_NTSC = 291,
    parameter int TMO_PAL  = 339,
    parameter int TMO_VGA  = 873,
    parameter int PER_NTSC = 269,
    parameter int PER_PAL  = 321,
    parameter int PER_VGA  = 526
) (
    input  logic [1:0]    mode_sel,
    output logic [CW-1:0] tmo_lim,
    output logic [CW-1:0] per_last
);
    localparam logic [CW-1:0] TN = CW'(TMO_NTSC);
    localparam logic [CW-1:0] TP = CW'(TMO_PAL);
    localparam logic [CW-1:0] TV = CW'(TMO_VGA);
    localparam logic [CW-1:0] PN = CW'(PER_NTSC - 1);
    localparam logic [CW-1:0] PP = CW'(PER_PAL - 1);
    localparam logic [CW-1:0] PV = CW'(PER_VGA - 1);

    vmode_e mode;

    always_comb begin
        mode = decode_mode(mode_sel);
        unique case (mode)
            VM_VGA:  begin tmo_lim = TV; per_last = PV; end
            VM_PAL:  begin tmo_lim = TP; per_last = PP; end
            default: begin tmo_lim = TN; per_last = PN; end
        endcase
    end
endmodule

// File: rtl/nosig_loss_watch.sv
module nosig_loss_watch #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_stb,
    input  logic          vsync_in,
    input  logic [CW-1:0] tmo_lim,
    output logic          no_sig,
    output logic          declare
);
    typedef struct packed {
        logic [CW-1:0] watch;
        logic          nosig;
    } lw_s;

    lw_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        declare = 1'b0;
        if (vsync_in) begin
            st_d.watch = '0;
            st_d.nosig = 1'b0;
        end else if (line_stb && !st_q.nosig) begin
            if (st_q.watch >= tmo_lim) begin
                st_d.nosig = 1'b1;
                declare    = 1'b1;
            end else begin
                st_d.watch = st_q.watch + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign no_sig = st_q.nosig;
endmodule

// File: rtl/nosig_frame_pacer.sv
module nosig_frame_pacer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_stb,
    input  logic          vsync_in,
    input  logic          no_sig,
    input  logic          declare,
    input  logic [CW-1:0] per_last,
    output logic          vst,
    output logic          frame_evt
);
    typedef struct packed {
        logic [CW-1:0] lines;
        logic          vst;
    } fp_s;

    fp_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.vst  = 1'b0;
        frame_evt = 1'b0;
        if (vsync_in) begin
            st_d.lines = '0;
            st_d.vst   = 1'b1;
            frame_evt  = 1'b1;
        end else if (declare) begin
            st_d.lines = '0;
        end else if (no_sig && line_stb) begin
            if (st_q.lines >= per_last) begin
                st_d.lines = '0;
                st_d.vst   = 1'b1;
                frame_evt  = 1'b1;
            end else begin
                st_d.lines = st_q.lines + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign vst = st_q.vst;
endmodule

// File: rtl/nosig_inv_gen.sv
module nosig_inv_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic frame_evt,
    input  logic inv_line,
    output logic frp,
    output logic xfrp
);
    typedef struct packed {
        logic pos;
        logic neg;
    } inv_s;

    inv_s st_d, st_q;
    logic flip;

    always_comb begin
        flip     = inv_line ? line_stb : frame_evt;
        st_d.pos = st_q.pos ^ flip;
        st_d.neg = ~(st_q.pos ^ flip);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= 2'b01;
        else
            st_q <= st_d;
    end

    assign frp  = st_q.pos;
    assign xfrp = st_q.neg;
endmodule

// File: rtl/nosig_vgen.sv
module nosig_vgen #(
    parameter int TMO_NTSC = 291,
    parameter int TMO_PAL  = 339,
    parameter int TMO_VGA  = 873,
    parameter int PER_NTSC = 269,
    parameter int PER_PAL  = 321,
    parameter int PER_VGA  = 526
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_stb,
    input  logic       vsync_in,
    input  logic [1:0] mode_sel,
    input  logic       inv_line,
    output logic       vst,
    output logic       frp,
    output logic       xfrp,
    output logic       no_sig
);
    localparam int MAX_T = (TMO_NTSC > TMO_PAL)
                         ? ((TMO_NTSC > TMO_VGA) ? TMO_NTSC : TMO_VGA)
                         : ((TMO_PAL > TMO_VGA) ? TMO_PAL : TMO_VGA);
    localparam int CW = $clog2(MAX_T + 2) + 1;

    logic [CW-1:0] tmo_lim, per_last;
    logic          declare, frame_evt;

    nosig_mode_limits #(
        .CW(CW), .TMO_NTSC(TMO_NTSC), .TMO_PAL(TMO_PAL), .TMO_VGA(TMO_VGA),
        .PER_NTSC(PER_NTSC), .PER_PAL(PER_PAL), .PER_VGA(PER_VGA)
    ) u_lim (
        .mode_sel(mode_sel), .tmo_lim(tmo_lim), .per_last(per_last)
    );

    nosig_loss_watch #(.CW(CW)) u_watch (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync_in(vsync_in),
        .tmo_lim(tmo_lim), .no_sig(no_sig), .declare(declare)
    );

    nosig_frame_pacer #(.CW(CW)) u_pace (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync_in(vsync_in),
        .no_sig(no_sig), .declare(declare), .per_last(per_last),
        .vst(vst), .frame_evt(frame_evt)
    );

    nosig_inv_gen u_inv (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_evt(frame_evt),
        .inv_line(inv_line), .frp(frp), .xfrp(xfrp)
    );
endmodule

// File: rtl/nosig_vgen_chk.sv
module nosig_vgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_stb,
    input logic       vsync_in,
    input logic [1:0] mode_sel,
    input logic       inv_line,
    input logic       vst,
    input logic       frp,
    input logic       xfrp,
    input logic       no_sig
);
    a_r5_sync_gives_vst: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_in |=> (vst && !no_sig));

    a_r5_vst_single: assert property (@(posedge clk) disable iff (!rst_n)
        (vst && !$past(vsync_in) && !no_sig) |-> 1'b0);

    a_r6_present_vst_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (vst && !no_sig) |-> $past(vsync_in));

    a_r3_loss_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_sig) |-> ($past(line_stb) && !$past(vsync_in)));

    a_r7_frame_flip_with_vst: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!inv_line) && !$stable(frp)) |-> vst);

    a_r8_line_flip: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_line && line_stb) |-> !$stable(frp));

    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (xfrp != frp));
endmodule

bind nosig_vgen nosig_vgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync_in(vsync_in),
    .mode_sel(mode_sel), .inv_line(inv_line), .vst(vst), .frp(frp),
    .xfrp(xfrp), .no_sig(no_sig)
);

// File: tb/nosig_vgen_test.sv
module nosig_vgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       vsync_in = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic       inv_line = 1'b0;
    logic       vst, frp, xfrp, no_sig;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nosig_vgen uut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync_in(vsync_in),
        .mode_sel(mode_sel), .inv_line(inv_line), .vst(vst), .frp(frp),
        .xfrp(xfrp), .no_sig(no_sig)
    );

    // behavioural reference
    int m_watch = 0;
    int m_free = 0;
    bit m_ns = 0, m_vst = 0, m_frp = 0;

    function automatic int limit_of(input logic [1:0] m);
        if (m == 2'b01) return 291;
        if (m == 2'b00) return 339;
        return 873;
    endfunction

    function automatic int period_of(input logic [1:0] m);
        if (m[1]) return 526;
        return m[0] ? 269 : 321;
    endfunction

    always @(posedge clk) begin
        bit frame;
        frame = 0;
        if (!rst_n) begin
            m_watch = 0; m_free = 0; m_ns = 0; m_vst = 0; m_frp = 0;
        end else begin
            m_vst = 0;
            if (vsync_in) begin
                m_watch = 0; m_free = 0; m_ns = 0; m_vst = 1; frame = 1;
            end else if (line_stb) begin
                if (!m_ns) begin
                    m_watch++;
                    if (m_watch > limit_of(mode_sel)) begin
                        m_ns = 1; m_free = 0;
                    end
                end else begin
                    m_free++;
                    if (m_free >= period_of(mode_sel)) begin
                        m_free = 0; m_vst = 1; frame = 1;
                    end
                end
            end
            if (inv_line ? line_stb : frame) m_frp = ~m_frp;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            if (fails < 40)
                $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(m_ns ? "R4 vst" : "R6 vst", vst, m_vst);
            check("R3 no_sig", no_sig, m_ns);
            check(inv_line ? "R8 frp" : "R7 frp", frp, m_frp);
            check("R9 xfrp", xfrp, ~frp);
        end
    end

    task automatic one_line();
        @(negedge clk); line_stb = 1'b1;
        @(negedge clk); line_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) one_line();
    endtask

    task automatic sync_pulse(input bit with_line);
        @(negedge clk); vsync_in = 1'b1; line_stb = with_line;
        @(negedge clk); vsync_in = 1'b0; line_stb = 1'b0;
        check("R5 vst after sync", vst, 1'b1);
        check("R5 no_sig cleared", no_sig, 1'b0);
        @(negedge clk);
        check("R5 vst one cycle", vst, 1'b0);
    endtask

    // loss boundary for the current mode: timeout strobes keep flag low, next sets it
    task automatic loss_edge(input string req, input int tmo);
        lines(tmo);
        check(req, no_sig, 1'b0);
        one_line();
        check(req, no_sig, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 vst", vst, 1'b0);
        check("R1 no_sig", no_sig, 1'b0);
        check("R1 frp", frp, 1'b0);
        check("R1 xfrp", xfrp, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", no_sig | vst | frp, 1'b0);

        // NTSC, frame inversion, signal present
        mode_sel = 2'b01; inv_line = 1'b0;
        for (int f = 0; f < 3; f++) begin sync_pulse(0); lines(262); end
        sync_pulse(0);
        loss_edge("R2 R3 NTSC timeout 291", 291);
        lines(269 * 2 + 5);
        sync_pulse(0);
        lines(40);

        // PAL, line inversion
        mode_sel = 2'b00; inv_line = 1'b1;
        sync_pulse(0);
        loss_edge("R2 R3 PAL timeout 339", 339);
        lines(321 * 2 + 3);
        inv_line = 1'b0;
        lines(330);
        sync_pulse(0);

        // VGA, bit 0 ignored, sync landing on a line strobe
        mode_sel = 2'b11; inv_line = 1'b0;
        sync_pulse(1);
        loss_edge("R2 R10 VGA timeout 873", 873);
        lines(526 + 10);
        mode_sel = 2'b10;
        sync_pulse(0);
        lines(500);
        sync_pulse(0);
        lines(20);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule